// File: doc/BRIEF.md
# Disk Controller Host Register File

This block is the register bank that a host processor sees on a floppy disk controller. The host reaches it over an 8-bit bidirectional data bus. Access uses an active-low chip select, active-low read and write strobes, and a two-bit register address. Behind the bus are five registers: command, status, track, sector and data.

The command and status registers share one address. The command register can only be written and the status register can only be read. The status value comes from the command sequencer, which sits outside this block, as does the disk data path.

While the sequencer reports busy, the block refuses new commands and sector loads. The one exception is a force-interrupt command, which is always taken. The block also owns the interrupt request line. A completion pulse from the sequencer or an accepted force-interrupt sets it. A status read or an accepted command write clears it.

Top module: `fdc_host_regs`

## Requirements
- R1: The register address selects as follows: 0 reads status and writes command, 1 is the track register, 2 is the sector register, and 3 is the data register. Addresses 1 to 3 read back the value last written.
- R2: The block drives the data bus only while chip select and read strobe are both low. At all other times the bus is high impedance.
- R3: A write to address 0 loads the command register and appears on `cmd_o`. A read of address 0 always returns `status_i`, never the command.
- R4: While `busy_i` is high, a command write whose upper nibble is not 1101 is ignored: `cmd_o`, `cmd_valid_o` and `irq_o` are all left unchanged.
- R5: A command write whose upper nibble is 1101 (force interrupt) is accepted even while busy, and it sets `irq_o`.
- R6: While `busy_i` is high, writes to the sector register are ignored. Track and data writes are still accepted.
- R7: A one-cycle `cmd_done_i` pulse sets `irq_o` on the next clock edge.
- R8: Reading status, or an accepted command write, clears `irq_o`. When a set and a clear fall on the same edge, the set wins.
- R9: Every accepted command write raises `cmd_valid_o` for exactly one cycle, in the cycle after the capturing edge.
- R10: Writes are captured on the rising clock edge while chip select and write strobe are low. The synchronous reset `rst` clears every register, `cmd_valid_o` and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| dbus | inout | 8 | Bidirectional host data bus |
| busy_i | input | 1 | Busy flag from the command sequencer |
| cmd_done_i | input | 1 | Command completion pulse from the sequencer |
| status_i | input | 8 | Status byte supplied by the sequencer |
| cmd_o | output | 8 | Current command register |
| cmd_valid_o | output | 1 | One-cycle pulse after each accepted command |
| track_o | output | 8 | Track register |
| sector_o | output | 8 | Sector register |
| data_o | output | 8 | Data register |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a force-interrupt write that lands while the sequencer is busy. That single write must be both a set and a clear of the interrupt, and the set must win. A second hard case makes a completion pulse coincide with an ordinary command write on the same edge. The bench holds `busy_i` high, loads a force-interrupt byte, and checks both `cmd_o` and `irq_o`. It then releases busy and raises `cmd_done_i` in the very cycle that the write strobe is low. This proves that the set still wins over the clear.

// File: rtl/fdc_hregs_pkg.sv
package fdc_hregs_pkg;
  localparam int DW = 8;
  localparam int NREG = 4;
  localparam logic [3:0] FORCE_NIBBLE = 4'hD;

  typedef enum logic [1:0] {
    SEL_CMDSTAT = 2'd0,
    SEL_TRACK   = 2'd1,
    SEL_SECTOR  = 2'd2,
    SEL_DATA    = 2'd3
  } sel_e;

  function automatic logic is_force_int(input logic [DW-1:0] c);
    return c[DW-1 -: 4] == FORCE_NIBBLE;
  endfunction

  function automatic logic cmd_allowed(input logic busy, input logic [DW-1:0] c);
    return !busy || is_force_int(c);
  endfunction
endpackage

// File: rtl/fdc_bus_decode.sv
module fdc_bus_decode
  import fdc_hregs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [1:0]      addr,
  output logic [NREG-1:0] wr_sel,
  output logic [NREG-1:0] rd_sel,
  output logic            bus_oe
);
  logic rd_act, wr_act;
  assign rd_act = !cs_n && !rd_n;
  assign wr_act = !cs_n && !wr_n;
  assign bus_oe = rd_act;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wr_sel[i] = wr_act && (addr == i[1:0]);
    assign rd_sel[i] = rd_act && (addr == i[1:0]);
  end

  a_r1_one_write_sel: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_sel));
  a_r2_read_needs_cs: assert property (@(posedge clk) disable iff (rst) (|rd_sel) |-> (!cs_n && !rd_n));
endmodule

// File: rtl/fdc_reg_bank.sv
module fdc_reg_bank
  import fdc_hregs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  logic [NREG-1:0] wr_sel,
  input  logic [DW-1:0]   din,
  output logic [DW-1:0]   cmd_q,
  output logic [DW-1:0]   trk_q,
  output logic [DW-1:0]   sec_q,
  output logic [DW-1:0]   dat_q,
  output logic            cmd_accept,
  output logic            force_accept,
  output logic            cmd_valid_q
);
  logic sec_load;
  assign cmd_accept   = wr_sel[SEL_CMDSTAT] && cmd_allowed(busy, din);
  assign force_accept = cmd_accept && is_force_int(din);
  assign sec_load     = wr_sel[SEL_SECTOR] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0; trk_q <= '0; sec_q <= '0; dat_q <= '0; cmd_valid_q <= 1'b0;
    end else begin
      cmd_valid_q <= cmd_accept;
      if (cmd_accept) cmd_q <= din;
      if (wr_sel[SEL_TRACK]) trk_q <= din;
      if (sec_load) sec_q <= din;
      if (wr_sel[SEL_DATA]) dat_q <= din;
    end
  end

  a_r4_busy_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_sel[SEL_CMDSTAT] && !is_force_int(din)) |=> ($stable(cmd_q) && !cmd_valid_q));
  a_r5_force_taken: assert property (@(posedge clk) disable iff (rst)
    (wr_sel[SEL_CMDSTAT] && is_force_int(din)) |=> (cmd_q == $past(din)));
  a_r6_sector_locked: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_sel[SEL_SECTOR]) |=> $stable(sec_q));
  a_r9_valid_single: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_q |=> (!cmd_valid_q || $past(cmd_accept)));
endmodule

// File: rtl/fdc_irq_ctrl.sv
module fdc_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic done_evt,
  input  logic force_evt,
  input  logic cmd_evt,
  input  logic stat_rd,
  output logic irq_q
);
  logic set_evt, clr_evt;
  assign set_evt = done_evt || force_evt;
  assign clr_evt = cmd_evt || stat_rd;

  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (set_evt) irq_q <= 1'b1;
    else if (clr_evt) irq_q <= 1'b0;
  end

  a_r7_done_sets: assert property (@(posedge clk) disable iff (rst) done_evt |=> irq_q);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !done_evt && !force_evt) |=> !irq_q);
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (!set_evt && !clr_evt) |=> $stable(irq_q));
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_hregs_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [1:0]   addr,
  inout  wire  [7:0]   dbus,
  input  logic         busy_i,
  input  logic         cmd_done_i,
  input  logic [7:0]   status_i,
  output logic [7:0]   cmd_o,
  output logic         cmd_valid_o,
  output logic [7:0]   track_o,
  output logic [7:0]   sector_o,
  output logic [7:0]   data_o,
  output logic         irq_o
);
  logic [NREG-1:0] wr_sel, rd_sel;
  logic            bus_oe, cmd_accept, force_accept;
  logic [DW-1:0]   rdata;

  fdc_bus_decode u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wr_sel(wr_sel), .rd_sel(rd_sel), .bus_oe(bus_oe));

  fdc_reg_bank u_bank (
    .clk(clk), .rst(rst), .busy(busy_i), .wr_sel(wr_sel), .din(dbus),
    .cmd_q(cmd_o), .trk_q(track_o), .sec_q(sector_o), .dat_q(data_o),
    .cmd_accept(cmd_accept), .force_accept(force_accept), .cmd_valid_q(cmd_valid_o));

  fdc_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .done_evt(cmd_done_i), .force_evt(force_accept),
    .cmd_evt(cmd_accept), .stat_rd(rd_sel[SEL_CMDSTAT]), .irq_q(irq_o));

  always_comb begin
    case (sel_e'(addr))
      SEL_CMDSTAT: rdata = status_i;
      SEL_TRACK:   rdata = track_o;
      SEL_SECTOR:  rdata = sector_o;
      default:     rdata = data_o;
    endcase
  end

  assign dbus = bus_oe ? rdata : 'z;

  a_r3_cmd_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_sel[SEL_CMDSTAT] && !busy_i) |=> (cmd_o == $past(dbus)));
endmodule

// File: tb/sim_fdc_host_regs.sv
`timescale 1ns/1ps
module sim_fdc_host_regs;
  logic clk = 0, rst = 1;
  logic cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0;
  logic busy_i = 0, cmd_done_i = 0;
  logic [7:0] status_i = 8'hA5;
  logic [7:0] tb_d = 0;
  logic tb_en = 0;
  wire  [7:0] dbus;
  logic [7:0] cmd_o, track_o, sector_o, data_o;
  logic cmd_valid_o, irq_o;
  int checks = 0, failures = 0;
  logic [7:0] rv;

  assign dbus = tb_en ? tb_d : 'z;
  always #2 clk = ~clk;

  fdc_host_regs u0 (.clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .dbus(dbus), .busy_i(busy_i), .cmd_done_i(cmd_done_i),
    .status_i(status_i), .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o),
    .track_o(track_o), .sector_o(sector_o), .data_o(data_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; tb_d = v; tb_en = 1; cs_n = 0; wr_n = 0;
    @(negedge clk); cs_n = 1; wr_n = 1; tb_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; cs_n = 0; rd_n = 0; #1 v = dbus;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic t_reset;
    #1;
    chk("R2 idle bus z", dbus, 8'hzz);
    chk("R10 irq reset", {7'b0, irq_o}, 8'h00);
    chk("R10 cmd reset", cmd_o, 8'h00);
    rd(2'd1, rv); chk("R10 track reset", rv, 8'h00);
    rd(2'd2, rv); chk("R10 sector reset", rv, 8'h00);
  endtask

  task automatic t_decode;
    wr(2'd1, 8'h12); wr(2'd2, 8'h34); wr(2'd3, 8'h56);
    rd(2'd1, rv); chk("R1 track", rv, 8'h12);
    rd(2'd2, rv); chk("R1 sector", rv, 8'h34);
    rd(2'd3, rv); chk("R1 data", rv, 8'h56);
  endtask

  task automatic t_bus_z;
    @(negedge clk); addr = 2'd1; cs_n = 1; rd_n = 0; #1 chk("R2 cs high z", dbus, 8'hzz);
    cs_n = 0; rd_n = 1; #1 chk("R2 rd high z", dbus, 8'hzz);
    cs_n = 1;
  endtask

  task automatic t_command;
    wr(2'd0, 8'h08);
    chk("R9 valid pulse", {7'b0, cmd_valid_o}, 8'h01);
    chk("R3 cmd out", cmd_o, 8'h08);
    @(negedge clk); chk("R9 valid single", {7'b0, cmd_valid_o}, 8'h00);
    rd(2'd0, rv); chk("R3 addr0 reads status", rv, 8'hA5);
  endtask

  task automatic t_busy;
    @(negedge clk); cmd_done_i = 1; @(negedge clk); cmd_done_i = 0;
    chk("R7 done sets irq", {7'b0, irq_o}, 8'h01);
    busy_i = 1;
    wr(2'd0, 8'h20);
    chk("R4 cmd ignored", cmd_o, 8'h08);
    chk("R4 no valid", {7'b0, cmd_valid_o}, 8'h00);
    chk("R4 irq kept", {7'b0, irq_o}, 8'h01);
    wr(2'd2, 8'h77); rd(2'd2, rv); chk("R6 sector locked", rv, 8'h34);
    wr(2'd1, 8'h99); rd(2'd1, rv); chk("R6 track allowed", rv, 8'h99);
    rd(2'd0, rv); chk("R8 status read clears", {7'b0, irq_o}, 8'h00);
    wr(2'd0, 8'hD3);
    chk("R5 force accepted", cmd_o, 8'hD3);
    chk("R5 force sets irq", {7'b0, irq_o}, 8'h01);
    busy_i = 0;
  endtask

  task automatic t_clear;
    wr(2'd0, 8'h10);
    chk("R8 cmd write clears", {7'b0, irq_o}, 8'h00);
    @(negedge clk); addr = 0; tb_d = 8'h44; tb_en = 1; cs_n = 0; wr_n = 0; cmd_done_i = 1;
    @(negedge clk); cs_n = 1; wr_n = 1; tb_en = 0; cmd_done_i = 0;
    chk("R8 set wins", {7'b0, irq_o}, 8'h01);
    chk("R10 write captured", cmd_o, 8'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_decode(); t_bus_z(); t_command(); t_busy(); t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule